// File: doc/BRIEF.md
# Digital I/O Port Register Bank

This block is the register file for a 56-line digital I/O card. The card has 24 latched output lines, 24 isolated input lines and one 8-line bank of TTL lines that can work as inputs or outputs. A host reaches all of them through a plain synchronous byte bus with 16 addresses. One control bit sets the direction of the TTL bank. The bank's output latch and its pin inputs sit at separate addresses, so software can read back what it last wrote and can also read what the pins really carry.

The block does not detect changes of state and does not generate interrupts. A neighbouring block does that work. This block only passes that block's status bytes, clear strobes, enable byte and interrupt pin level across the bus. Writing any value to the top address performs a software reset. The software reset clears every writable register, so after it the TTL bank is an input again. The reset is also passed on as a one-cycle pulse. Input pins go through a synchronizer before they can be read. Read data is registered: the byte for the address presented at a clock edge appears after that edge.

The register bus is a control path with no back-pressure. Every access completes in one cycle, so it has no valid/ready handshake.

Top module: `dio_regbank`

## Requirements
- R1: After the hardware reset, `fet_out`, `ttl_out`, `ttl_oe`, `cos_en`, `cos_clr_stb`, `soft_rst` and `bus_rdata` are all 0.
- R2: Addresses 0, 1 and 2 are output latches. Address k drives `fet_out[8k+7:8k]`. A read returns the last value written.
- R3: Address 3 is the TTL output latch. It drives `ttl_out` and reads back the last value written.
- R4: Addresses 4, 5 and 6 return the synchronized `iso_in` bytes, with address 4+k returning bits 8k+7:8k. A write to any of these addresses changes no output and no other register.
- R5: Address 7 returns the synchronized `ttl_pin_in`. A write to it leaves `ttl_out` and the TTL latch unchanged.
- R6: Address 12 is a read/write control byte. `ttl_oe` equals bit 1 of this byte: 1 selects TTL output mode and 0 releases the pins.
- R7: Address 13 always reads 0. A write to it changes nothing.
- R8: Address 14 is a read/write enable byte that drives `cos_en`.
- R9: Addresses 8 to 11 return byte k = address−8 of `cos_status`. A write there raises `cos_clr_stb[k]` for exactly one cycle after the write edge, with `cos_clr_data` holding the written byte. At most one strobe bit is high at a time.
- R10: A write of any value to address 15 clears the output latches, the TTL latch, the control byte and the enable byte at that edge. It also raises `soft_rst` for one cycle.
- R11: A read of address 15 returns `{7'b0, irq_pin}`.
- R12: A change on `iso_in` or `ttl_pin_in` first appears in `bus_rdata` after the third rising edge that follows it: two synchronizer edges plus the read register edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write enable for the addressed byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address presented at the prior edge |
| iso_in | input | 24 | Isolated input pins (asynchronous) |
| ttl_pin_in | input | 8 | TTL pin levels (asynchronous) |
| cos_status | input | 32 | Status bytes from the change-of-state block |
| irq_pin | input | 1 | Level of the card's interrupt output |
| fet_out | output | 24 | Output latch drive |
| ttl_out | output | 8 | TTL output latch drive |
| ttl_oe | output | 1 | TTL bank output enable |
| cos_en | output | 8 | Change-of-state enable byte |
| cos_clr_stb | output | 4 | One-cycle clear strobe per status byte |
| cos_clr_data | output | 8 | Byte written with the clear strobe |
| soft_rst | output | 1 | One-cycle software reset pulse |

## Verification
The hardest case to reach from the ports is the read latency of an input pin while the synchronizer is still settling. The bench changes `iso_in` and then reads the same address back to back. The first two reads must still show the old byte and the third must show the new one. A second hard case is proving that writes to input and reserved addresses are dropped. The bench follows each such write with a read-back of the latches and control state that a wrong decode would have overwritten.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 4;
  localparam int FET_BYTES = 3;
  localparam int ISO_BYTES = 3;
  localparam int COS_BYTES = 4;
  localparam int FET_W     = FET_BYTES * BYTE_W;
  localparam int ISO_W     = ISO_BYTES * BYTE_W;
  localparam int COS_W     = COS_BYTES * BYTE_W;
  localparam int CTL_TTL_DIR_BIT = 1;

  // byte offsets that software decodes
  localparam logic [ADDR_W-1:0] A_FET0   = 4'd0;
  localparam logic [ADDR_W-1:0] A_TTLLAT = 4'd3;
  localparam logic [ADDR_W-1:0] A_ISO0   = 4'd4;
  localparam logic [ADDR_W-1:0] A_TTLPIN = 4'd7;
  localparam logic [ADDR_W-1:0] A_COS0   = 4'd8;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd12;
  localparam logic [ADDR_W-1:0] A_RSVD   = 4'd13;
  localparam logic [ADDR_W-1:0] A_COSEN  = 4'd14;
  localparam logic [ADDR_W-1:0] A_SWRST  = 4'd15;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dio_byte_latches.sv
module dio_byte_latches #(
  parameter int NB = 1,
  parameter int BW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_clr,
  input  logic [NB-1:0]  wr_sel,
  input  logic [BW-1:0]  wdata,
  output logic [NB*BW-1:0] q
);
  for (genvar k = 0; k < NB; k++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q[k*BW +: BW] <= '0;
      else if (soft_clr)  q[k*BW +: BW] <= '0;
      else if (wr_sel[k]) q[k*BW +: BW] <= wdata;
    end
  end
endmodule

// File: rtl/dio_rd_mux.sv
module dio_rd_mux
  import dio_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [FET_W-1:0]  fet_q,
  input  logic [BYTE_W-1:0] ttl_q,
  input  logic [ISO_W-1:0]  iso_s,
  input  logic [BYTE_W-1:0] ttl_s,
  input  logic [COS_W-1:0]  cos_status,
  input  logic [BYTE_W-1:0] ctl_q,
  input  logic [BYTE_W-1:0] cosen_q,
  input  logic              irq_pin,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [1:0] lane;
  assign lane = addr[1:0];

  always_comb begin
    rd_byte = '0;
    if (addr < A_TTLLAT)       rd_byte = fet_q[lane*BYTE_W +: BYTE_W];
    else if (addr == A_TTLLAT) rd_byte = ttl_q;
    else if (addr < A_TTLPIN)  rd_byte = iso_s[lane*BYTE_W +: BYTE_W];
    else if (addr == A_TTLPIN) rd_byte = ttl_s;
    else if (addr < A_CTRL)    rd_byte = cos_status[lane*BYTE_W +: BYTE_W];
    else if (addr == A_CTRL)   rd_byte = ctl_q;
    else if (addr == A_COSEN)  rd_byte = cosen_q;
    else if (addr == A_SWRST)  rd_byte = {{(BYTE_W-1){1'b0}}, irq_pin};
  end
endmodule

// File: rtl/dio_regbank.sv
module dio_regbank
  import dio_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int TTL_MODE_BIT = CTL_TTL_DIR_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [ISO_W-1:0]  iso_in,
  input  logic [BYTE_W-1:0] ttl_pin_in,
  input  logic [COS_W-1:0]  cos_status,
  input  logic              irq_pin,
  output logic [FET_W-1:0]  fet_out,
  output logic [BYTE_W-1:0] ttl_out,
  output logic              ttl_oe,
  output logic [BYTE_W-1:0] cos_en,
  output logic [COS_BYTES-1:0] cos_clr_stb,
  output logic [BYTE_W-1:0] cos_clr_data,
  output logic              soft_rst
);
  logic [FET_BYTES-1:0] wr_fet;
  logic [COS_BYTES-1:0] wr_cos;
  logic wr_ttl, wr_ctl, wr_cosen, soft_clr;
  logic [BYTE_W-1:0] ctl_q, rd_byte, ttl_s;
  logic [ISO_W-1:0]  iso_s;

  for (genvar k = 0; k < FET_BYTES; k++) begin : g_fet_dec
    assign wr_fet[k] = bus_wr && (bus_addr == A_FET0 + ADDR_W'(k));
  end
  for (genvar k = 0; k < COS_BYTES; k++) begin : g_cos_dec
    assign wr_cos[k] = bus_wr && (bus_addr == A_COS0 + ADDR_W'(k));
  end
  assign wr_ttl   = bus_wr && (bus_addr == A_TTLLAT);
  assign wr_ctl   = bus_wr && (bus_addr == A_CTRL);
  assign wr_cosen = bus_wr && (bus_addr == A_COSEN);
  assign soft_clr = bus_wr && (bus_addr == A_SWRST);

  dio_byte_latches #(.NB(FET_BYTES), .BW(BYTE_W)) u_fet (
    .clk, .rst_n, .soft_clr, .wr_sel(wr_fet), .wdata(bus_wdata), .q(fet_out));
  dio_byte_latches #(.NB(1), .BW(BYTE_W)) u_ttl (
    .clk, .rst_n, .soft_clr, .wr_sel(wr_ttl), .wdata(bus_wdata), .q(ttl_out));
  dio_byte_latches #(.NB(1), .BW(BYTE_W)) u_ctl (
    .clk, .rst_n, .soft_clr, .wr_sel(wr_ctl), .wdata(bus_wdata), .q(ctl_q));
  dio_byte_latches #(.NB(1), .BW(BYTE_W)) u_cosen (
    .clk, .rst_n, .soft_clr, .wr_sel(wr_cosen), .wdata(bus_wdata), .q(cos_en));

  assign ttl_oe = ctl_q[TTL_MODE_BIT];

  dio_sync #(.W(ISO_W), .STAGES(SYNC_STAGES)) u_iso_sync (
    .clk, .rst_n, .d(iso_in), .q(iso_s));
  dio_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES)) u_ttl_sync (
    .clk, .rst_n, .d(ttl_pin_in), .q(ttl_s));

  dio_rd_mux u_rd (
    .addr(bus_addr), .fet_q(fet_out), .ttl_q(ttl_out), .iso_s(iso_s),
    .ttl_s(ttl_s), .cos_status(cos_status), .ctl_q(ctl_q),
    .cosen_q(cos_en), .irq_pin(irq_pin), .rd_byte(rd_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata    <= '0;
      cos_clr_stb  <= '0;
      cos_clr_data <= '0;
      soft_rst     <= 1'b0;
    end else begin
      bus_rdata    <= rd_byte;
      cos_clr_stb  <= wr_cos;
      soft_rst     <= soft_clr;
      if (|wr_cos) cos_clr_data <= bus_wdata;
    end
  end
endmodule

// File: rtl/dio_regbank_chk.sv
module dio_regbank_chk
  import dio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              irq_pin,
  input logic [FET_W-1:0]  fet_out,
  input logic [BYTE_W-1:0] ttl_out,
  input logic              ttl_oe,
  input logic [BYTE_W-1:0] cos_en,
  input logic [COS_BYTES-1:0] cos_clr_stb,
  input logic              soft_rst
);
  AST_FET0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_FET0) |=> fet_out[BYTE_W-1:0] == $past(bus_wdata)); // R2
  AST_INPUT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr >= A_ISO0 && bus_addr <= A_TTLPIN)
      |=> ($stable(fet_out) && $stable(ttl_out) && $stable(ttl_oe) && $stable(cos_en))); // R4
  AST_OE_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL) |=> ttl_oe == $past(bus_wdata[CTL_TTL_DIR_BIT])); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_RSVD) |=> bus_rdata == '0); // R7
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cos_clr_stb)); // R9
  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SWRST)
      |=> (fet_out == '0 && ttl_out == '0 && !ttl_oe && cos_en == '0 && soft_rst)); // R10
  AST_IRQ_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_SWRST) |=> bus_rdata == {{(BYTE_W-1){1'b0}}, $past(irq_pin)}); // R11
endmodule

bind dio_regbank dio_regbank_chk u_chk (.*);

// File: tb/dio_regbank_tb.sv
`timescale 1ns/1ps
module dio_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [23:0] iso_in = 24'h123456;
  logic [7:0]  ttl_pin_in = 8'h5A;
  logic [31:0] cos_status = 32'hDEADBEEF;
  logic        irq_pin = 1'b0;
  logic [23:0] fet_out;
  logic [7:0]  ttl_out;
  logic        ttl_oe;
  logic [7:0]  cos_en;
  logic [3:0]  cos_clr_stb;
  logic [7:0]  cos_clr_data;
  logic        soft_rst;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dio_regbank u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wr = 1'b0;
    @(negedge clk); d = bus_rdata;
  endtask

  // vector: {req[3:0], wr, addr[3:0], data[7:0], exp[7:0]}
  localparam int NV = 22;
  localparam logic [24:0] VEC [NV] = '{
    {4'd2,  1'b1, 4'd0,  8'hA5, 8'h00}, {4'd2,  1'b0, 4'd0,  8'h00, 8'hA5}, // R2
    {4'd2,  1'b1, 4'd1,  8'h3C, 8'h00}, {4'd2,  1'b0, 4'd1,  8'h00, 8'h3C},
    {4'd2,  1'b1, 4'd2,  8'h81, 8'h00}, {4'd2,  1'b0, 4'd2,  8'h00, 8'h81},
    {4'd3,  1'b1, 4'd3,  8'hF0, 8'h00}, {4'd3,  1'b0, 4'd3,  8'h00, 8'hF0}, // R3
    {4'd4,  1'b1, 4'd4,  8'hFF, 8'h00}, {4'd4,  1'b0, 4'd4,  8'h00, 8'h56}, // R4
    {4'd4,  1'b0, 4'd0,  8'h00, 8'hA5}, {4'd4,  1'b0, 4'd5,  8'h00, 8'h34},
    {4'd4,  1'b0, 4'd6,  8'h00, 8'h12},
    {4'd5,  1'b1, 4'd7,  8'hAA, 8'h00}, {4'd5,  1'b0, 4'd3,  8'h00, 8'hF0}, // R5
    {4'd5,  1'b0, 4'd7,  8'h00, 8'h5A},
    {4'd6,  1'b1, 4'd12, 8'h02, 8'h00}, {4'd6,  1'b0, 4'd12, 8'h00, 8'h02}, // R6
    {4'd7,  1'b1, 4'd13, 8'hFF, 8'h00}, {4'd7,  1'b0, 4'd13, 8'h00, 8'h00}, // R7
    {4'd8,  1'b1, 4'd14, 8'h11, 8'h00}, {4'd8,  1'b0, 4'd14, 8'h00, 8'h11}  // R8
  };

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 fet_out", 32'(fet_out), 32'h0);
    check("R1 ttl_out/oe", {ttl_out, 7'b0, ttl_oe}, 32'h0);
    check("R1 cos_en/stb/rst", {cos_en, cos_clr_stb, 3'b0, soft_rst}, 32'h0);
    check("R1 rdata", 32'(bus_rdata), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) bus_write(VEC[i][19:16], VEC[i][15:8]);
      else begin
        bus_read(VEC[i][19:16], rd);
        check($sformatf("R%0d addr %0d", VEC[i][24:21], VEC[i][19:16]), 32'(rd), 32'(VEC[i][7:0]));
      end
    end

    check("R2 fet_out drive", 32'(fet_out), 32'h813CA5);
    check("R3 ttl_out drive", 32'(ttl_out), 32'hF0);
    check("R6 ttl_oe set", 32'(ttl_oe), 32'h1);
    check("R8 cos_en drive", 32'(cos_en), 32'h11);
    bus_write(4'd12, 8'hFD);
    check("R6 ttl_oe cleared by bit1=0", 32'(ttl_oe), 32'h0);
    check("R7 latches intact after reserved write", 32'(fet_out), 32'h813CA5);

    // R9 status read and clear strobe
    bus_read(4'd8, rd);  check("R9 status byte0", 32'(rd), 32'hEF);
    bus_read(4'd11, rd); check("R9 status byte3", 32'(rd), 32'hDE);
    bus_write(4'd9, 8'h77);
    check("R9 strobe", {cos_clr_stb, cos_clr_data}, {4'b0010, 8'h77});
    @(negedge clk);
    check("R9 strobe one cycle", 32'(cos_clr_stb), 32'h0);

    // R11 irq level
    irq_pin = 1'b1;
    bus_read(4'd15, rd); check("R11 irq high", 32'(rd), 32'h01);
    irq_pin = 1'b0;
    bus_read(4'd15, rd); check("R11 irq low", 32'(rd), 32'h00);

    // R12 synchronizer latency
    @(negedge clk); iso_in = 24'h0000AB;
    bus_addr = 4'd4;
    @(negedge clk); check("R12 first read old", 32'(bus_rdata), 32'h56);
    @(negedge clk); check("R12 second read old", 32'(bus_rdata), 32'h56);
    @(negedge clk); check("R12 third read new", 32'(bus_rdata), 32'hAB);

    // R10 software reset
    bus_write(4'd12, 8'h02);
    bus_write(4'd15, 8'h5C);
    check("R10 pulse", 32'(soft_rst), 32'h1);
    check("R10 clears", {fet_out, ttl_out}, 32'h0);
    check("R10 clears ctl/en", {cos_en, 7'b0, ttl_oe}, 32'h0);
    @(negedge clk);
    check("R10 pulse one cycle", 32'(soft_rst), 32'h0);
    bus_read(4'd0, rd);  check("R10 latch reads 0", 32'(rd), 32'h0);
    bus_read(4'd12, rd); check("R10 ctl reads 0", 32'(rd), 32'h0);

    done = 1;
    finish_run();
  end
endmodule